// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software run one serial-flash transaction at a time through three 32-bit registers on a simple bus. Software first loads a command word and, when there is write payload, a data word. It then writes the control word with the start bit set. The control word also packs how many bytes to send and how many to receive. The engine lowers chip select and shifts the outgoing bytes out in SPI mode 0. The outgoing stream is the command byte, then the three address bytes, then payload bytes from the data word. Straight after the last sent byte, the engine clocks in the requested number of response bytes. These land right-aligned in the data word. A busy flag in the control word stays high until chip select has been released.

The engine knows nothing about flash opcodes: every transaction is framed only by the two byte counts. A two-bit clock select sets the serial clock to the system clock divided by 2, 4, 8 or 16. A two-bit size field is stored and read back unchanged, so software can preserve it across read-modify-write.

Top module: `spi_cmd_engine`

## Requirements
- R1: After synchronous reset the control word reads 0 (counts, start, busy, clock select and size all clear), chip select is high and the serial clock is low.
- R2: Offset 0x00 is control: bits [3:0] send count, [7:4] receive count, bit 8 start (reads 0), bit 16 busy (read-only), [18:17] size (stored as written), [25:24] clock select. All other control bits read 0. Offset 0x04 (command byte in [7:0], address in [31:8]) and offset 0x08 (data) read back what was written. Offset 0x0C reads 0.
- R3: A control write with bit 8 set while idle, and with a nonzero total count, starts a transaction. Chip select falls one cycle after the write. Busy reads 1 from the write until the transaction ends.
- R4: Sent byte k is taken as follows. Byte 0 is command [7:0]. Bytes 1..3 are the address, most significant first: [31:24], [23:16], [15:8]. Bytes 4..7 are data [7:0], [15:8], [23:16], [31:24]. Byte 8 and later are 0x00. Each byte goes out MSB first, and MOSI is low while receiving.
- R5: Received byte j (j = 0..3) is written to data bits [8j+7:8j]. Lanes beyond the receive count keep their prior value, and received bytes beyond the fourth are dropped.
- R6: SPI mode 0: the serial clock is low whenever chip select is high. MOSI never changes at a rising serial clock edge. MISO is sampled on the rising edge.
- R7: Chip select stays low without a break for exactly 16·2^sel system cycles per byte (send plus receive), where sel is the clock select. This gives one serial clock period of 2·2^sel cycles.
- R8: After chip select rises, busy stays 1 for at least one serial clock period (2·2^sel cycles).
- R9: While busy, control writes (including start), command writes and data writes change nothing.
- R10: A start with both counts zero does nothing: busy stays 0 and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A register read returns its value one cycle after the read strobe, so the bench samples read data on the second falling clock edge after raising the strobe. Chip select falls one cycle after a start write and then holds low for 16·2^sel cycles per byte. The bench counts low cycles on falling clock edges and compares the count with that figure, and it counts rising serial clock edges against eight per byte. Busy clears 2·2^sel cycles after chip select rises. A read issued on the first falling edge after chip select rises must therefore still see busy, while final results are read only after polling busy low.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned CNT_W      = 4;
  localparam int unsigned IDX_W      = CNT_W + 1;
  localparam int unsigned LANES      = REG_W / 8;

  localparam logic [3:0] OFS_CTRL    = 4'h0;
  localparam logic [3:0] OFS_CMD     = 4'h4;
  localparam logic [3:0] OFS_DATA    = 4'h8;

  localparam int unsigned B_START    = 8;
  localparam int unsigned B_BUSY     = 16;
  localparam int unsigned B_SIZE_LO  = 17;
  localparam int unsigned B_CSEL_LO  = 24;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_SHIFT,
    XS_GAP
  } xfer_state_t;

  // Outgoing byte for stream index idx; zero once past the send count.
  function automatic logic [7:0] pick_tx_byte(
    input logic [IDX_W-1:0] idx,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [REG_W-1:0] cmd_word,
    input logic [REG_W-1:0] data_word
  );
    logic [7:0] b;
    b = 8'h00;
    if (idx < {1'b0, tx_cnt}) begin
      case (idx)
        5'd0: b = cmd_word[7:0];
        5'd1: b = cmd_word[31:24];
        5'd2: b = cmd_word[23:16];
        5'd3: b = cmd_word[15:8];
        5'd4: b = data_word[7:0];
        5'd5: b = data_word[15:8];
        5'd6: b = data_word[23:16];
        5'd7: b = data_word[31:24];
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned MAX_HALF = 1 << ((1 << SEL_W) - 1);
  localparam int unsigned CW       = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // Half period is 2^sel cycles; tick marks each serial clock edge.
  assign limit = CW'((1 << sel) - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [REG_W-1:0] cmd_word,
  input  logic [REG_W-1:0] data_word,
  input  logic             tick,
  output logic             run,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             rx_we,
  output logic [1:0]       rx_lane,
  output logic [7:0]       rx_byte
);
  xfer_state_t      state_q;
  logic [IDX_W-1:0] byte_idx_q;
  logic [2:0]       bit_idx_q;
  logic             sck_q, cs_n_q, mosi_q, gap_half_q;
  logic [7:0]       rx_sr_q;
  logic             rx_we_q;
  logic [1:0]       rx_lane_q;
  logic [7:0]       rx_byte_q;

  logic [IDX_W-1:0] total, last_idx, rx_idx;
  logic [7:0]       cur_byte, next_byte, first_byte;
  logic [2:0]       next_bit;
  logic             in_rx, lane_ok;

  assign total      = {1'b0, tx_cnt} + {1'b0, rx_cnt};
  assign last_idx   = total - 1'b1;
  assign rx_idx     = byte_idx_q - {1'b0, tx_cnt};
  assign in_rx      = (byte_idx_q >= {1'b0, tx_cnt});
  assign lane_ok    = (rx_idx < IDX_W'(LANES));
  assign cur_byte   = pick_tx_byte(byte_idx_q, tx_cnt, cmd_word, data_word);
  assign next_byte  = pick_tx_byte(byte_idx_q + 1'b1, tx_cnt, cmd_word, data_word);
  assign first_byte = pick_tx_byte('0, tx_cnt, cmd_word, data_word);
  assign next_bit   = bit_idx_q - 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= XS_IDLE;
      byte_idx_q <= '0;
      bit_idx_q  <= 3'd7;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      mosi_q     <= 1'b0;
      gap_half_q <= 1'b0;
      rx_sr_q    <= '0;
      rx_we_q    <= 1'b0;
      rx_lane_q  <= '0;
      rx_byte_q  <= '0;
    end else begin
      rx_we_q <= 1'b0;
      case (state_q)
        XS_IDLE: begin
          if (start && (total != '0)) begin
            state_q    <= XS_SHIFT;
            cs_n_q     <= 1'b0;
            byte_idx_q <= '0;
            bit_idx_q  <= 3'd7;
            mosi_q     <= first_byte[7];
          end
        end
        XS_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q   <= 1'b1;
              rx_sr_q <= {rx_sr_q[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              if (bit_idx_q != 3'd0) begin
                bit_idx_q <= next_bit;
                mosi_q    <= cur_byte[next_bit];
              end else begin
                if (in_rx && lane_ok) begin
                  rx_we_q   <= 1'b1;
                  rx_lane_q <= rx_idx[1:0];
                  rx_byte_q <= rx_sr_q;
                end
                if (byte_idx_q == last_idx) begin
                  state_q    <= XS_GAP;
                  cs_n_q     <= 1'b1;
                  mosi_q     <= 1'b0;
                  gap_half_q <= 1'b0;
                end else begin
                  byte_idx_q <= byte_idx_q + 1'b1;
                  bit_idx_q  <= 3'd7;
                  mosi_q     <= next_byte[7];
                end
              end
            end
          end
        end
        XS_GAP: begin
          if (tick) begin
            gap_half_q <= 1'b1;
            if (gap_half_q) state_q <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign run     = (state_q != XS_IDLE);
  assign busy    = (state_q != XS_IDLE);
  assign sck     = sck_q;
  assign cs_n    = cs_n_q;
  assign mosi    = mosi_q;
  assign rx_we   = rx_we_q;
  assign rx_lane = rx_lane_q;
  assign rx_byte = rx_byte_q;

  // R6: clock parked low whenever the device is deselected
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sck_q);

  // R6: data out never moves on a rising serial clock edge
  a_r6_mosi_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |-> $stable(mosi_q));

  // R4: MOSI rests low outside a transaction
  a_r4_mosi_rest_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == XS_IDLE) |-> !mosi_q);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CLK_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [CNT_W-1:0]     tx_cnt_q, rx_cnt_q;
  logic [1:0]           size_q;
  logic [CLK_SEL_W-1:0] clk_sel_q;
  logic [REG_W-1:0]     cmd_q;
  logic [REG_W-1:0]     data_q;
  logic                 start_q;
  logic [31:0]          rdata_q;

  logic eng_busy, busy_any, run, tick;
  logic rx_we;
  logic [1:0] rx_lane;
  logic [7:0] rx_byte;
  logic wr_ctrl, wr_cmd, wr_data, go;
  logic [31:0] ctrl_view;
  logic unused_wbits;

  assign busy_any = eng_busy | start_q;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && !busy_any;
  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD))  && !busy_any;
  assign wr_data  = bus_wr && (bus_addr == ADDR_W'(OFS_DATA)) && !busy_any;
  assign go       = wr_ctrl && bus_wdata[B_START] && (bus_wdata[7:0] != 8'h00);

  assign unused_wbits = ^{bus_wdata[31:26], bus_wdata[23:19], bus_wdata[16:9]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
      size_q    <= '0;
      clk_sel_q <= '0;
      cmd_q     <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= go;
      if (wr_ctrl) begin
        tx_cnt_q  <= bus_wdata[CNT_W-1:0];
        rx_cnt_q  <= bus_wdata[2*CNT_W-1:CNT_W];
        size_q    <= bus_wdata[B_SIZE_LO+1:B_SIZE_LO];
        clk_sel_q <= bus_wdata[B_CSEL_LO+CLK_SEL_W-1:B_CSEL_LO];
      end
      if (wr_cmd) cmd_q <= bus_wdata;
    end
  end

  // Data word: one byte lane per generate step, fed by bus or receiver.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[8*g +: 8] <= '0;
      end else if (wr_data) begin
        data_q[8*g +: 8] <= bus_wdata[8*g +: 8];
      end else if (rx_we && (rx_lane == 2'(g))) begin
        data_q[8*g +: 8] <= rx_byte;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CNT_W-1:0]                         = tx_cnt_q;
    ctrl_view[2*CNT_W-1:CNT_W]                   = rx_cnt_q;
    ctrl_view[B_BUSY]                            = busy_any;
    ctrl_view[B_SIZE_LO+1:B_SIZE_LO]             = size_q;
    ctrl_view[B_CSEL_LO+CLK_SEL_W-1:B_CSEL_LO]   = clk_sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL): rdata_q <= ctrl_view;
        ADDR_W'(OFS_CMD):  rdata_q <= cmd_q;
        ADDR_W'(OFS_DATA): rdata_q <= data_q;
        default:           rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;

  spi_clk_div #(.SEL_W(CLK_SEL_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (clk_sel_q),
    .tick (tick)
  );

  spi_xfer_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .tx_cnt    (tx_cnt_q),
    .rx_cnt    (rx_cnt_q),
    .cmd_word  (cmd_q),
    .data_word (data_q),
    .tick      (tick),
    .run       (run),
    .busy      (eng_busy),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso),
    .rx_we     (rx_we),
    .rx_lane   (rx_lane),
    .rx_byte   (rx_byte)
  );

  // Checker state: cycles chip select has been high, saturating.
  logic [4:0] cs_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n) cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 5'd31) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  // R3: an accepted start selects the device on the next cycle
  a_r3_start_selects: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !spi_cs_n);

  // R8: busy drops only after a full serial period of deselect
  a_r8_gap_before_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> (cs_hi_cnt >= (5'd2 << clk_sel_q)));

  // R9: control fields frozen while busy
  a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_any |=> ($stable(tx_cnt_q) && $stable(rx_cnt_q) && $stable(clk_sel_q) && $stable(cmd_q)));

  // R10: an empty start leaves the engine idle
  a_r10_empty_start: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[B_START]
     && (bus_wdata[7:0] == 8'h00) && !busy_any) |=> !busy_any);

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int errors = 0, checks = 0;
  logic [7:0] sbyte [0:31];
  logic [7:0] mcap  [0:31];
  int spos = 0, rises = 0, cs_falls = 0, cs_low = 0;

  always #10 clk = ~clk;

  spi_cmd_engine uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // Flash-side model: mode 0, streams sbyte[] out, captures MOSI.
  always @(negedge spi_cs_n) begin
    spos = 0;
    cs_falls++;
    spi_miso = sbyte[0][7];
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    mcap[spos/8] = {mcap[spos/8][6:0], spi_mosi};
    rises++;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    spos++;
    spi_miso = sbyte[spos/8][7-(spos%8)];
  end
  always @(negedge clk) if (!spi_cs_n) cs_low++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(4'h0, v);
      if (!v[16]) return;
    end
    chk("R3 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) begin sbyte[i] = 8'h00; mcap[i] = 8'h00; end
    rises = 0; cs_falls = 0; cs_low = 0;
  endtask

  function automatic logic [7:0] exp_tx(input int k, input int tx, input logic [31:0] c, input logic [31:0] d);
    if (k >= tx || k > 7) return 8'h00;
    if (k == 0) return c[7:0];
    if (k < 4) return c[8*(4-k) +: 8];
    return d[8*(k-4) +: 8];
  endfunction

  // Loads registers, runs a transaction, checks framing and busy gap.
  task automatic run_xfer(input int tx, input int rx, input int sel,
                          input logic [31:0] c, input logic [31:0] d);
    logic [31:0] v;
    wr(4'h4, c);
    wr(4'h8, d);
    rises = 0; cs_falls = 0; cs_low = 0;
    wr(4'h0, (32'(sel) << 24) | 32'h100 | (32'(rx) << 4) | 32'(tx));
    @(posedge spi_cs_n);
    rd(4'h0, v);
    chk("R8 busy held after deselect", {31'd0, v[16]}, 32'd1);
    wait_idle();
    chk("R7 chip select low cycles", 32'(cs_low), 32'(16 * (1 << sel) * (tx + rx)));
    chk("R6 rising clock edges", 32'(rises), 32'(8 * (tx + rx)));
    for (int k = 0; k < tx + rx; k++)
      chk($sformatf("R4 mosi byte %0d", k), {24'd0, mcap[k]}, {24'd0, exp_tx(k, tx, c, d)});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v);
    chk("R1 control after reset", v, 32'h0);
    chk("R1 cs_n high", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sck low", {31'd0, spi_sck}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h0, 32'hFFFF_FE53);
    rd(4'h0, v);
    chk("R2 control readback", v, 32'h0306_0053);
    chk("R2 no start from write without bit 8", 32'(cs_falls), 32'd0);
    wr(4'h4, 32'hCAFE_F00D);
    rd(4'h4, v);
    chk("R2 command readback", v, 32'hCAFE_F00D);
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, v);
    chk("R2 data readback", v, 32'h1234_5678);
    rd(4'hC, v);
    chk("R2 unused offset", v, 32'h0);
  endtask

  task automatic t_opcode_only();
    clear_model();
    run_xfer(1, 0, 0, 32'h1234_5606, 32'h0);
  endtask

  task automatic t_signature();
    logic [31:0] v;
    clear_model();
    sbyte[4] = 8'h17;
    run_xfer(4, 1, 1, 32'hA1B2_C3AB, 32'hDEAD_BEEF);
    rd(4'h8, v);
    chk("R5 single byte right-aligned", v, 32'hDEAD_BE17);
  endtask

  task automatic t_program();
    logic [31:0] v;
    clear_model();
    run_xfer(8, 0, 0, 32'h0102_0302, 32'h4433_2211);
    rd(4'h8, v);
    chk("R5 data kept with no receive", v, 32'h4433_2211);
  endtask

  task automatic t_read4();
    logic [31:0] v;
    clear_model();
    sbyte[4] = 8'h5A; sbyte[5] = 8'h6B; sbyte[6] = 8'h7C; sbyte[7] = 8'h8D;
    run_xfer(4, 4, 2, 32'h0010_2003, 32'h0);
    rd(4'h8, v);
    chk("R5 four received bytes", v, 32'h8D7C_6B5A);
  endtask

  task automatic t_long_rx();
    logic [31:0] v;
    clear_model();
    for (int i = 1; i <= 6; i++) sbyte[i] = 8'(i);
    run_xfer(1, 6, 3, 32'h0000_009F, 32'hFFFF_FFFF);
    rd(4'h8, v);
    chk("R5 bytes beyond fourth dropped", v, 32'h0403_0201);
  endtask

  task automatic t_tx10();
    clear_model();
    run_xfer(10, 0, 0, 32'hABCD_EF01, 32'h8877_6655);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    clear_model();
    wr(4'h4, 32'h0A0B_0C0D);
    wr(4'h8, 32'h1111_2222);
    wr(4'h0, 32'h0300_0104);
    repeat (5) @(negedge clk);
    wr(4'h0, 32'h0000_0131);
    wr(4'h4, 32'h0000_0099);
    wr(4'h8, 32'h0000_0055);
    wait_idle();
    rd(4'h0, v);
    chk("R9 control unchanged", v, 32'h0300_0004);
    rd(4'h4, v);
    chk("R9 command unchanged", v, 32'h0A0B_0C0D);
    rd(4'h8, v);
    chk("R9 data unchanged", v, 32'h1111_2222);
    chk("R9 one transaction only", 32'(cs_falls), 32'd1);
    chk("R9 bytes sent", 32'(rises), 32'd32);
    chk("R9 first byte", {24'd0, mcap[0]}, 32'h0D);
    repeat (40) @(negedge clk);
    chk("R9 no late restart", 32'(cs_falls), 32'd1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    clear_model();
    wr(4'h0, 32'h0000_0100);
    rd(4'h0, v);
    chk("R10 busy stays 0", {31'd0, v[16]}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R10 no chip select", 32'(cs_falls), 32'd0);
    chk("R10 cs_n high", {31'd0, spi_cs_n}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin sbyte[i] = 8'h00; mcap[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_opcode_only();
    t_signature();
    t_program();
    t_read4();
    t_long_rx();
    t_tx10();
    t_busy_ignore();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule